// File: doc/BRIEF.md
# Periodic Interrupt Timer with Power-of-Two Prescaler

This block is a register-programmed timer that raises an interrupt at a fixed rate. It halves the system clock first. It then divides the result by a selectable power of two. Last, it counts down a reloadable modulus. Each time the down-counter expires, a sticky flag is set, and the interrupt output is that flag gated by an enable bit. Software programs the modulus for a rate F from clock S as (S/2)/P/F minus one. Loading the value without the minus one makes every period one prescaled count too long.

Two registers sit behind a one-bit select. A 16-bit control/status word holds the run, reload, flag and interrupt-enable bits in its low byte and the 4-bit prescaler select in its high byte. The second register is a 16-bit modulus. Every write carries two byte-lane enables. Any write that reaches the high lane of the control word restarts the prescaler, even when the value written is the same as before. A word-wide flag clear therefore stretches the period that is running, while a clear that touches only the low lane leaves the period exact.

Top module: `pit_timer`

## Requirements
- R1: After reset both registers read 0x0000 and `irq` is low.
- R2: With run (ctrl bit 0) and reload (ctrl bit 1) set, the flag (ctrl bit 2) rises every 2 × 2^PRE × (M+1) clocks. PRE is ctrl bits 11:8 and M is the modulus register (select = 1).
- R3: Writing 1 to ctrl bit 2 on the low lane clears the flag. Writing 0 there leaves it unchanged.
- R4: `irq` equals the flag ANDed with the interrupt enable (ctrl bit 3). While bit 3 is 0, `irq` stays low even when the flag is set.
- R5: A control write with the high lane enabled restarts the prescaler, even when the value written is unchanged. A word write issued d clocks after the flag rises lengthens that period by d+1 clocks.
- R6: A control write that enables only the low lane, for example a flag clear that keeps bits 0, 1 and 3 at their values, leaves the running period exact.
- R7: While run is 0, the prescaler and the down-counter are held, with the down-counter at M. The first flag appears 2 × 2^PRE × (M+1) clocks after the write that sets run.
- R8: Each byte lane (be[0] = bits 7:0, be[1] = bits 15:8) updates only its own byte of the selected register.
- R9: With reload clear, the counter wraps to all ones after it expires. The flag therefore does not rise again within the next 500 clocks for M = 3, PRE = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| sel | input | 1 | Register select: 0 = control/status, 1 = modulus |
| be | input | 2 | Byte-lane enables, bit 1 = high byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume that each write strobe lasts exactly one clock, with `sel`, `be` and `wdata` valid alongside it. They also assume that reset is applied synchronously before any write. The stimulus changes inputs only on falling edges, and every write lasts a single cycle. The bench gives each new configuration with the timer stopped, clearing the flag in the same write. Flag clears are issued well before the next expiry, so a clear never coincides with a flag set.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int MOD_W = 16,
  parameter int PRE_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        sel,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic             en_q, rld_q, ie_q, flag_q, half_q;
  logic [PRE_W-1:0] pre_q;
  logic [MOD_W-1:0] mod_q, cnt_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [PC_W:0]    lim;
  logic [15:0]      mod16, mod_nx;

  wire ctrl_wr = wr_en && !sel;
  wire mod_wr  = wr_en && sel;
  wire lo_wr   = ctrl_wr && be[0];
  wire hi_wr   = ctrl_wr && be[1];

  assign lim    = ((PC_W+1)'(1) << pre_q) - (PC_W+1)'(1);
  wire ptick    = en_q && half_q && !hi_wr && ({1'b0, pcnt_q} == lim);
  wire expire   = ptick && (cnt_q == '0);

  assign mod16  = 16'(mod_q);
  assign mod_nx = {be[1] ? wdata[15:8] : mod16[15:8],
                   be[0] ? wdata[7:0]  : mod16[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rld_q  <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      pre_q  <= '0;
      mod_q  <= '0;
    end else begin
      if (lo_wr) begin
        en_q  <= wdata[0];
        rld_q <= wdata[1];
        ie_q  <= wdata[3];
      end
      if (hi_wr)  pre_q <= wdata[8 +: PRE_W];
      if (mod_wr) mod_q <= MOD_W'(mod_nx);
      if (expire)                   flag_q <= 1'b1;
      else if (lo_wr && wdata[2])   flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (!en_q) begin
      half_q <= 1'b0;
      pcnt_q <= '0;
      cnt_q  <= mod_q;
    end else begin
      if (hi_wr) begin
        half_q <= 1'b0;
        pcnt_q <= '0;
      end else begin
        half_q <= ~half_q;
        if (half_q) pcnt_q <= ptick ? '0 : pcnt_q + PC_W'(1);
      end
      if (ptick) cnt_q <= (cnt_q == '0) ? (rld_q ? mod_q : '1) : cnt_q - MOD_W'(1);
    end
  end

  always_comb begin
    if (sel) begin
      rdata = mod16;
    end else begin
      rdata = '0;
      rdata[8 +: PRE_W] = pre_q;
      rdata[3:0] = {ie_q, flag_q, rld_q, en_q};
    end
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int MOD_W = 16,
  parameter int PRE_W = 4,
  parameter int PC_W  = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             sel,
  input logic [1:0]       be,
  input logic [15:0]      wdata,
  input logic             irq,
  input logic             en_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic             half_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [PC_W-1:0]  pcnt_q,
  input logic [MOD_W-1:0] cnt_q
);
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pcnt_q == '0 && !half_q)); // R7

  AST_HI_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel && be[1]) |=> (pcnt_q == '0 && !half_q)); // R5

  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(cnt_q) == '0)); // R2

  AST_ZERO_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && wr_en && !sel && be[0] && !wdata[2]) |=> flag_q); // R3

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq); // R4

  AST_LANE_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !sel && be[1]) |=> $stable(pre_q)); // R8
endmodule

bind pit_timer pit_timer_chk #(.MOD_W(MOD_W), .PRE_W(PRE_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .be(be), .wdata(wdata),
  .irq(irq), .en_q(en_q), .ie_q(ie_q), .flag_q(flag_q), .half_q(half_q),
  .pre_q(pre_q), .pcnt_q(pcnt_q), .cnt_q(cnt_q)
);

// File: tb/pit_timer_tb.sv
`timescale 1ns/1ps
module pit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        sel = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pit_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .be(be),
                   .wdata(wdata), .rdata(rdata), .irq(irq));

  // {pre[4], modulus[16], expected period[12]}
  localparam logic [31:0] VEC [7] = '{
    {4'd0, 16'd3, 12'd8},   {4'd1, 16'd4, 12'd20},  {4'd2, 16'd2, 12'd24},
    {4'd3, 16'd0, 12'd16},  {4'd4, 16'd9, 12'd320}, {4'd0, 16'd0, 12'd2},
    {4'd5, 16'd1, 12'd128}
  };

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [1:0] b, input logic [15:0] d);
    sel = s; be = b; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; be = 2'b00; sel = 1'b0;
  endtask

  task automatic meas(input int start, output int n);
    n = start;
    while (!irq && n < 60000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic setup(input logic [3:0] p, input logic [15:0] m, input logic [7:0] lo);
    wr(1'b0, 2'b11, 16'h0004);
    wr(1'b1, 2'b11, m);
    wr(1'b0, 2'b11, {4'h0, p, lo});
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sel = 1'b0; #1; chk(rdata, 0, "R1 ctrl after reset");
    sel = 1'b1; #1; chk(rdata, 0, "R1 modulus after reset");
    chk(irq, 0, "R1 irq after reset");
    sel = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      setup(VEC[i][31:28], VEC[i][27:12], 8'h0B);
      meas(0, n);
      chk(n, VEC[i][11:0], $sformatf("R7 first period vec %0d", i));
      wr(1'b0, 2'b01, 16'h000F);
      meas(1, n);
      chk(n, VEC[i][11:0], $sformatf("R2 R6 reload period vec %0d", i));
    end

    setup(4'd2, 16'd3, 8'h0B);
    meas(0, n);
    chk(n, 32, "R7 first period pre2 m3");
    repeat (2) @(negedge clk);
    wr(1'b0, 2'b11, 16'h020F);
    meas(3, n);
    chk(n, 35, "R5 word clear stretches period");
    wr(1'b0, 2'b01, 16'h000F);
    meas(1, n);
    chk(n, 32, "R6 low-byte clear keeps period");

    setup(4'd0, 16'd1, 8'h03);
    repeat (5) @(negedge clk);
    wr(1'b0, 2'b01, 16'h0000);
    #1; chk(rdata[2], 1, "R3 flag set before clear");
    chk(irq, 0, "R4 irq masked with enable off");
    wr(1'b0, 2'b01, 16'h0000);
    #1; chk(rdata[2], 1, "R3 writing 0 keeps flag");
    wr(1'b0, 2'b01, 16'h0008);
    chk(irq, 1, "R4 irq follows flag with enable on");
    wr(1'b0, 2'b01, 16'h000C);
    #1; chk(rdata[2], 0, "R3 writing 1 clears flag");
    chk(irq, 0, "R4 irq low after clear");

    wr(1'b1, 2'b11, 16'h1234);
    wr(1'b1, 2'b01, 16'hABCD);
    sel = 1'b1; #1; chk(rdata, 16'h12CD, "R8 modulus low lane only");
    sel = 1'b0;
    wr(1'b1, 2'b10, 16'h5600);
    sel = 1'b1; #1; chk(rdata, 16'h56CD, "R8 modulus high lane only");
    sel = 1'b0;
    wr(1'b0, 2'b10, 16'h05FF);
    #1; chk(rdata, 16'h0508, "R8 ctrl high lane only");

    setup(4'd0, 16'd3, 8'h09);
    meas(0, n);
    chk(n, 8, "R9 one-shot first expiry");
    wr(1'b0, 2'b01, 16'h000D);
    n = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (irq) n++;
    end
    chk(n, 0, "R9 no second flag without reload");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule